// File: doc/BRIEF.md
# Watchdog Timer with Dual-Clear Mode

This block is a watchdog counter for a small processor core. It counts ticks from one of three selectable sources: a free-running RC oscillator tick, an instruction-rate tick derived inside the block from the system clock divided by four, or a 32768 Hz real-time-clock tick. The RC and RTC ticks arrive as single-cycle pulses already synchronised to the system clock. A configuration input picks one of four timeouts, each a power of two, from 2^BASE_EXP up to 2^(BASE_EXP+3) ticks. With the default BASE_EXP of 12 this gives the range 2^12 to 2^15 ticks.

Software keeps the watchdog from expiring with clear strobes. In single-clear mode either strobe restarts the count. In dual-clear mode both strobes must arrive, in either order, before the counter restarts. A strobe that has arrived is held as a pending bit until its partner comes. Entering HALT also restarts the count. On expiry the block sends a one-cycle chip-reset pulse if the core is running, or a one-cycle warm-reset pulse if it is halted. The warm reset is meant to restore only the program counter and the stack pointer. Expiry also sets a sticky timeout flag.

Top module: `wdt_dual_clear`

## Requirements
- R1: `srcSel` picks the tick source. 0 selects `tickRc`, 1 selects the internal instruction tick, 2 selects `tickRtc` and 3 selects no source. Ticks on a source that is not selected are not counted.
- R2: With `toSel` = s, the timeout occurs on the 2^(BASE_EXP+s)-th counted tick after the last restart. The reset pulse appears on the clock edge that samples that tick.
- R3: With `dualMode` = 0, a pulse on either `clr1` or `clr2` restarts the count.
- R4: With `dualMode` = 1, the count restarts only once both `clr1` and `clr2` have pulsed, in either order or in the same cycle. One of them alone does not change the timeout instant.
- R5: A `haltEntry` pulse restarts the count in either mode and drops any pending dual-clear strobe.
- R6: While `enable` is 0, nothing is counted and no reset pulse is produced. Clear strobes are not remembered, and the count begins again from zero once the block is re-enabled.
- R7: A timeout with `halted` = 0 gives a one-cycle `chipRstPulse`. A timeout with `halted` = 1 gives a one-cycle `warmRstPulse`. The two pulses are never high together.
- R8: `toFlag` goes to 1 on any timeout. It stays at 1 until `rstN` is low or `toFlagClr` is 1. A timeout in the same cycle as `toFlagClr` leaves it at 1.
- R9: The instruction tick fires once every four system clocks while `halted` = 0. It stops while `halted` = 1.
- R10: After a timeout the count restarts from zero and pending dual-clear strobes are dropped.
- R11: With `rstN` low, both reset pulses and `toFlag` are 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | External reset, active low, synchronous |
| enable | input | 1 | Watchdog enable |
| dualMode | input | 1 | 1 = both clear strobes needed, 0 = either one is enough |
| srcSel | input | 2 | Tick source: 0 RC, 1 instruction, 2 RTC, 3 none |
| toSel | input | 2 | Timeout exponent offset: 2^(BASE_EXP+toSel) ticks |
| tickRc | input | 1 | RC oscillator tick pulse |
| tickRtc | input | 1 | RTC tick pulse |
| halted | input | 1 | Core is in HALT |
| haltEntry | input | 1 | One-cycle strobe on HALT entry |
| clr1 | input | 1 | Software clear strobe 1 |
| clr2 | input | 1 | Software clear strobe 2 |
| toFlagClr | input | 1 | Clears the timeout flag |
| chipRstPulse | output | 1 | One-cycle full reset request |
| warmRstPulse | output | 1 | One-cycle warm reset request |
| toFlag | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with BASE_EXP = 4, so the four timeouts are 16, 32, 64 and 128 ticks instead of thousands. This makes every timeout setting, and the exact tick on which each one fires, reachable in a short run. The small exponent also lets the bench cover several timeouts in a row within one run: restart after expiry, a pending strobe dropped by a timeout, and the instruction tick resuming after HALT.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SRC_RC    = 2'd0,
    SRC_INSTR = 2'd1,
    SRC_RTC   = 2'd2,
    SRC_NONE  = 2'd3
  } wdtSrc_e;

  typedef struct packed {
    logic clrCnt;
    logic tick;
  } wdtCtl_s;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int DIV_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dualMode,
  input  logic [1:0] srcSel,
  input  logic       tickRc,
  input  logic       tickRtc,
  input  logic       halted,
  input  logic       haltEntry,
  input  logic       clr1,
  input  logic       clr2,
  input  logic       toFlagClr,
  input  logic       wrap,
  output wdtCtl_s    ctl,
  output logic       chipRstPulse,
  output logic       warmRstPulse,
  output logic       toFlag
);
  logic instrTick;
  logic selTick;
  logic pend1, pend2;
  logic swClr;
  logic clrNow;
  wdtSrc_e src;

  // instruction-rate tick: system clock divided by 2^DIV_LOG2, frozen in HALT
  generate
    if (DIV_LOG2 == 0) begin : g_noDiv
      assign instrTick = !halted;
    end else begin : g_div
      logic [DIV_LOG2-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)       divCnt <= '0;
        else if (!halted) divCnt <= divCnt + 1'b1;
      end
      assign instrTick = !halted && (divCnt == {DIV_LOG2{1'b1}});
    end
  endgenerate

  assign src = wdtSrc_e'(srcSel);

  always_comb begin
    unique case (src)
      SRC_RC:    selTick = tickRc;
      SRC_INSTR: selTick = instrTick;
      SRC_RTC:   selTick = tickRtc;
      default:   selTick = 1'b0;
    endcase
  end

  assign swClr  = dualMode ? ((pend1 | clr1) & (pend2 | clr2)) : (clr1 | clr2);
  assign clrNow = !enable || swClr || haltEntry;

  always_comb begin
    ctl.clrCnt = clrNow;
    ctl.tick   = enable && selTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrNow || wrap || !dualMode) begin
      pend1 <= 1'b0;
      pend2 <= 1'b0;
    end else begin
      pend1 <= pend1 | clr1;
      pend2 <= pend2 | clr2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipRstPulse <= 1'b0;
      warmRstPulse <= 1'b0;
      toFlag       <= 1'b0;
    end else begin
      chipRstPulse <= wrap && !halted;
      warmRstPulse <= wrap && halted;
      if (wrap)           toFlag <= 1'b1;
      else if (toFlagClr) toFlag <= 1'b0;
    end
  end

  p_one_kind_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(chipRstPulse && warmRstPulse));
  p_chip_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    chipRstPulse |=> !chipRstPulse);
  p_warm_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    warmRstPulse |=> !warmRstPulse);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !wrap);
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (toFlag && !toFlagClr) |=> toFlag);
  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (halted && src == SRC_INSTR) |-> !ctl.tick);
  p_lone_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && dualMode && clr1 && !clr2 && !pend2 && !haltEntry) |-> !ctl.clrCnt);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  wdtCtl_s    ctl,
  input  logic [1:0] toSel,
  output logic       wrap
);
  localparam int CW = BASE_EXP + 3;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastVal;

  // 2^(BASE_EXP+toSel) - 1
  assign lastVal = {CW{1'b1}} >> (2'd3 - toSel);
  assign wrap    = ctl.tick && !ctl.clrCnt && (cnt >= lastVal);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clrCnt) cnt <= '0;
    else if (ctl.tick)       cnt <= wrap ? '0 : cnt + 1'b1;
  end

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrCnt |=> (cnt == '0));
  p_wrap_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.tick && !ctl.clrCnt) |=> $stable(cnt));
endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 12,
  parameter int DIV_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       dualMode,
  input  logic [1:0] srcSel,
  input  logic [1:0] toSel,
  input  logic       tickRc,
  input  logic       tickRtc,
  input  logic       halted,
  input  logic       haltEntry,
  input  logic       clr1,
  input  logic       clr2,
  input  logic       toFlagClr,
  output logic       chipRstPulse,
  output logic       warmRstPulse,
  output logic       toFlag
);
  wdtCtl_s ctl;
  logic    wrap;

  wdt_ctrl #(.DIV_LOG2(DIV_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .dualMode(dualMode),
    .srcSel(srcSel), .tickRc(tickRc), .tickRtc(tickRtc), .halted(halted),
    .haltEntry(haltEntry), .clr1(clr1), .clr2(clr2), .toFlagClr(toFlagClr),
    .wrap(wrap), .ctl(ctl), .chipRstPulse(chipRstPulse),
    .warmRstPulse(warmRstPulse), .toFlag(toFlag)
  );

  wdt_datapath #(.BASE_EXP(BASE_EXP)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .toSel(toSel), .wrap(wrap)
  );
endmodule

// File: tb/sim_wdt_dual_clear.sv
module sim_wdt_dual_clear;
  localparam int BASE = 4;

  logic clk = 0;
  logic rstN = 0, enable = 0, dualMode = 0;
  logic [1:0] srcSel = 0, toSel = 0;
  logic tickRc = 0, tickRtc = 0, halted = 0, haltEntry = 0;
  logic clr1 = 0, clr2 = 0, toFlagClr = 0;
  logic chipRstPulse, warmRstPulse, toFlag;

  int cyc = 0, checks = 0, fails = 0, evCount = 0, lastEvCyc = 0;
  bit done = 0;

  typedef struct {int at; bit warm; bit loose;} ev_t;
  ev_t expQ[$];

  wdt_dual_clear #(.BASE_EXP(BASE), .DIV_LOG2(2)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .dualMode(dualMode),
    .srcSel(srcSel), .toSel(toSel), .tickRc(tickRc), .tickRtc(tickRtc),
    .halted(halted), .haltEntry(haltEntry), .clr1(clr1), .clr2(clr2),
    .toFlagClr(toFlagClr), .chipRstPulse(chipRstPulse),
    .warmRstPulse(warmRstPulse), .toFlag(toFlag)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when a reset pulse appears
  always @(negedge clk) begin
    if (rstN && (chipRstPulse || warmRstPulse)) begin
      ev_t e;
      evCount++;
      lastEvCyc = cyc;
      if (expQ.size() == 0) begin
        chk(0, "R7 unexpected reset pulse at cycle", cyc, -1);
      end else begin
        e = expQ.pop_front();
        chk(e.loose || e.at == cyc, "R2 timeout cycle", cyc, e.at);
        chk(warmRstPulse == e.warm && chipRstPulse == !e.warm,
            "R7 pulse kind (warm)", warmRstPulse, e.warm);
      end
    end
  end

  task automatic ticks(int n, bit rtc, bit rc);
    repeat (n) begin
      @(negedge clk); tickRtc = rtc; tickRc = rc;
      @(negedge clk); tickRtc = 0; tickRc = 0;
    end
  endtask

  task automatic finalTick(bit rtc, bit warm, bit flagClr);
    @(negedge clk);
    expQ.push_back('{cyc + 1, warm, 1'b0});
    if (rtc) tickRtc = 1; else tickRc = 1;
    toFlagClr = flagClr;
    @(negedge clk); tickRtc = 0; tickRc = 0; toFlagClr = 0;
  endtask

  task automatic pulseClr1; @(negedge clk); clr1 = 1; @(negedge clk); clr1 = 0; endtask
  task automatic pulseClr2; @(negedge clk); clr2 = 1; @(negedge clk); clr2 = 0; endtask
  task automatic pulseHalt; @(negedge clk); haltEntry = 1; @(negedge clk); haltEntry = 0; endtask

  task automatic drained(string tag);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete();
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end

  initial begin
    int st, ev0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!chipRstPulse && !warmRstPulse && !toFlag, "R11 outputs in reset",
        {chipRstPulse, warmRstPulse, toFlag}, 0);
    rstN = 1; enable = 1;

    // R1/R2: RC source, 16 ticks
    ticks(15, 0, 1);
    finalTick(0, 0, 0);
    drained("R2 toSel0 timeout missing");
    chk(toFlag == 1, "R8 flag set", toFlag, 1);
    @(negedge clk); toFlagClr = 1; @(negedge clk); toFlagClr = 0;
    chk(toFlag == 0, "R8 flag cleared", toFlag, 1'b0);

    // R10: restart from zero after timeout
    ticks(15, 0, 1);
    finalTick(0, 0, 0);
    drained("R10 restart timeout missing");

    // R2: toSel=2 -> 64 ticks
    toSel = 2; pulseHalt();
    ticks(63, 0, 1);
    finalTick(0, 0, 0);
    drained("R2 toSel2 timeout missing");
    toSel = 0;

    // R3 single mode: each strobe clears
    ticks(10, 0, 1); pulseClr1();
    ticks(15, 0, 1); pulseClr2();
    ticks(15, 0, 1);
    finalTick(0, 0, 0);
    drained("R3 single clear");

    // R4 dual mode: lone strobe no effect
    dualMode = 1;
    ticks(10, 0, 1); pulseClr1();
    ticks(5, 0, 1);
    finalTick(0, 0, 0);
    drained("R4 lone clr1 ignored");
    // R10: pending dropped by that timeout -> clr2 alone ignored
    ticks(10, 0, 1); pulseClr2();
    ticks(5, 0, 1);
    finalTick(0, 0, 0);
    drained("R10 pending dropped at timeout");
    // R4: both strobes, reverse order
    ticks(10, 0, 1); pulseClr2(); ticks(3, 0, 1); pulseClr1();
    ticks(15, 0, 1);
    finalTick(0, 0, 0);
    drained("R4 both strobes clear");

    // R5: halt entry clears and drops pending
    ticks(5, 0, 1); pulseClr1(); ticks(5, 0, 1); pulseHalt();
    ticks(10, 0, 1); pulseClr2();
    ticks(5, 0, 1);
    finalTick(0, 0, 0);
    drained("R5 halt entry clear");
    dualMode = 0;

    // R7 halted -> warm reset; R8 set wins over clear
    halted = 1;
    ticks(15, 0, 1);
    finalTick(0, 1, 1);
    drained("R7 warm reset");
    chk(toFlag == 1, "R8 set wins over clear", toFlag, 1);
    halted = 0;

    // R1: RTC source, RC ticks ignored
    srcSel = 2; pulseHalt();
    ticks(20, 0, 1);
    ticks(15, 1, 0);
    finalTick(1, 0, 0);
    drained("R1 rtc source");
    // R1: no source
    srcSel = 3; ev0 = evCount;
    ticks(40, 1, 1);
    chk(evCount == ev0, "R1 no source counts nothing", evCount - ev0, 0);

    // R9: instruction tick rate
    @(negedge clk); srcSel = 1; clr1 = 1; st = cyc;
    expQ.push_back('{0, 1'b0, 1'b1});
    @(negedge clk); clr1 = 0;
    repeat (78) @(negedge clk);
    srcSel = 3;
    chk(expQ.size() == 0, "R9 instr timeout seen", expQ.size(), 0);
    chk(lastEvCyc - st >= 58 && lastEvCyc - st <= 70, "R9 instr period",
        lastEvCyc - st, 64);
    expQ.delete();

    // R9: frozen while halted
    halted = 1; pulseHalt();
    @(negedge clk); srcSel = 1; ev0 = evCount;
    repeat (150) @(negedge clk);
    chk(evCount == ev0, "R9 no count in halt", evCount - ev0, 0);
    @(negedge clk); halted = 0; st = cyc;
    expQ.push_back('{0, 1'b0, 1'b1});
    repeat (78) @(negedge clk);
    srcSel = 0;
    chk(expQ.size() == 0, "R9 resume timeout seen", expQ.size(), 0);
    chk(lastEvCyc - st >= 58 && lastEvCyc - st <= 70, "R9 resume period",
        lastEvCyc - st, 64);
    expQ.delete();

    // R6: disabled
    pulseHalt();
    enable = 0; dualMode = 1; ev0 = evCount;
    ticks(60, 0, 1); pulseClr1();
    chk(evCount == ev0, "R6 no timeout when disabled", evCount - ev0, 0);
    enable = 1;
    ticks(10, 0, 1); pulseClr2();
    ticks(5, 0, 1);
    finalTick(0, 0, 0);
    drained("R6 strobes not remembered");
    dualMode = 0;

    // R11: reset clears flag
    chk(toFlag == 1, "R8 flag set before reset", toFlag, 1);
    @(negedge clk); rstN = 0;
    @(negedge clk);
    chk(!toFlag && !chipRstPulse && !warmRstPulse, "R11 reset clears",
        {chipRstPulse, warmRstPulse, toFlag}, 0);
    rstN = 1;
    ticks(15, 0, 1);
    finalTick(0, 0, 0);
    drained("R11 count zero after reset");

    finishRun();
  end
endmodule